// File: doc/BRIEF.md
# Byte-Mapped Multiply, Divide and Accumulate Unit

This block gives an 8-bit host a 16-bit arithmetic engine behind a small register window. The host picks an operation in a control register and writes two 16-bit operands one byte at a time. Writing the upper byte of the second operand starts the work. The engine supports a signed product, a division with a signed dividend and an unsigned divisor, and a running signed multiply-accumulate into a 40-bit total. The outcome is read back as five bytes, along with a status byte that carries the accumulator overflow flag and a busy flag.

Products and quotients come from an iterative shift-and-add or shift-and-subtract engine. It runs for one cycle per operand bit on magnitudes and fixes the signs when it finishes. While the engine runs, every host write is dropped. The host polls the busy bit before it reads the result or issues the next operation.

Top module: `arith_mdu`

## Requirements
- R1: After reset, result bytes 0 to 4 and the status byte all read 0x00.
- R2: Write index 0 is control, 1 and 2 are the low and high bytes of operand A, 3 and 4 the low and high bytes of operand B. Read indices 0 to 4 return result bits 7:0 up to 39:32, index 5 is status (bit 7 overflow, bit 0 busy), and other read indices return 0x00.
- R3: Control bits 1:0 pick the operation: 0 is multiply, 1 is divide, and 2 or 3 is multiply-accumulate. A multiply leaves the signed 32-bit product of A and B, sign-extended to 40 bits, in the result.
- R4: Division treats A as signed and B as unsigned and truncates toward zero. The quotient goes in result bits 15:0 and the remainder, which takes the dividend's sign, in bits 31:16, both as 16-bit two's complement. Bits 39:32 are zero.
- R5: Dividing by a B of zero gives a result of zero.
- R6: Multiply-accumulate adds the signed product of A and B to the 40-bit total, modulo 2^40.
- R7: Each completed multiply-accumulate sets the overflow flag to 1 exactly when the unwrapped total is at least 2^40 or below zero, and to 0 otherwise. Multiply, divide and control writes leave the flag unchanged.
- R8: A control write with bit 1 set clears the 40-bit total. A control write with bit 1 clear leaves the total as it is.
- R9: A write to index 4 while idle starts the operation. Busy reads 1 for exactly 16 cycles, and the result is final once busy returns to 0.
- R10: While busy, all writes are ignored, including a control write that would clear the total or change the mode, and a second trigger.
- R11: Every operation leaves operand B at zero. A division also leaves operand A at zero. Operand bytes that are not rewritten keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrIdx | input | 3 | Register index of the write |
| wrData | input | 8 | Write data byte |
| rdIdx | input | 3 | Register index of the read |
| rdData | output | 8 | Read data byte, combinational from rdIdx |

## Verification
The assertions assume the host writes at most one byte per cycle through the index port, and that reset is asserted before the first operation. They also assume the busy window is measured from the write to index 4 that was accepted. The bench holds to these assumptions. It drives each write for exactly one cycle between falling edges and polls the status byte until busy clears before it reads results. It deliberately issues writes while busy only in the R10 scenario, and that is the case where the assertions on busy length and total stability must still hold.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int REG_IDXW = 3;

  localparam logic [REG_IDXW-1:0] IDX_CTRL   = 3'd0;
  localparam logic [REG_IDXW-1:0] IDX_A_LO   = 3'd1;
  localparam logic [REG_IDXW-1:0] IDX_A_HI   = 3'd2;
  localparam logic [REG_IDXW-1:0] IDX_B_LO   = 3'd3;
  localparam logic [REG_IDXW-1:0] IDX_B_HI   = 3'd4;
  localparam logic [REG_IDXW-1:0] IDX_STATUS = 3'd5;

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_DIV = 2'd1,
    OP_MAC = 2'd2
  } opKind_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    wrALo;
    logic    wrAHi;
    logic    wrBLo;
    logic    start;
    logic    step;
    logic    finish;
    logic    clrSum;
    opKind_e op;
  } mduStrobes_t;

  function automatic opKind_e decodeMode(input logic [1:0] m);
    if (m[1])      return OP_MAC;
    else if (m[0]) return OP_DIV;
    else           return OP_MUL;
  endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_IDXW-1:0] wrIdx,
  input  logic [7:0]          wrData,
  output mduStrobes_t         strb,
  output logic                busy
);
  localparam int CNTW = $clog2(OPW);
  localparam logic [CNTW-1:0] LAST_STEP = CNTW'(OPW - 1);

  logic [1:0]      modeQ;
  logic [CNTW-1:0] stepCnt;
  opKind_e         runOp;
  logic            accept;

  assign accept = wrEn && !busy;

  always_comb begin
    strb        = '0;
    strb.wrALo  = accept && (wrIdx == IDX_A_LO);
    strb.wrAHi  = accept && (wrIdx == IDX_A_HI);
    strb.wrBLo  = accept && (wrIdx == IDX_B_LO);
    strb.start  = accept && (wrIdx == IDX_B_HI);
    strb.clrSum = accept && (wrIdx == IDX_CTRL) && wrData[1];
    strb.step   = busy;
    strb.finish = busy && (stepCnt == LAST_STEP);
    strb.op     = strb.start ? decodeMode(modeQ) : runOp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 2'd0;
      busy    <= 1'b0;
      stepCnt <= '0;
      runOp   <= OP_MUL;
    end else begin
      if (accept && (wrIdx == IDX_CTRL)) modeQ <= wrData[1:0];
      if (strb.start) begin
        busy    <= 1'b1;
        stepCnt <= '0;
        runOp   <= decodeMode(modeQ);
      end else if (strb.finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      wrData,
  input  mduStrobes_t     strb,
  output logic [ACCW-1:0] sumQ,
  output logic            ovfQ
);
  localparam int PRODW = 2 * OPW;

  logic [OPW-1:0]   opA, opB, bFull, absA, absB;
  logic [PRODW-1:0] work, aux, workNx, auxNx, prod;
  logic [OPW-1:0]   sh, shNx, qSigned, rSigned;
  logic             negQ;
  logic [OPW:0]     trial;
  logic [ACCW:0]    prodExt, macSum;
  logic [ACCW-1:0]  divRes;

  // trigger byte joins the stored low byte in the same cycle
  assign bFull = {wrData, opB[OPW-9:0]};
  assign absA  = opA[OPW-1] ? -opA : opA;
  assign absB  = bFull[OPW-1] ? -bFull : bFull;

  // one iteration of the shared engine
  always_comb begin
    workNx = work;
    auxNx  = aux;
    shNx   = sh;
    trial  = '0;
    if (strb.op == OP_DIV) begin
      trial = {work[OPW-1:0], sh[OPW-1]};
      shNx  = {sh[OPW-2:0], 1'b0};
      if (trial >= aux[OPW:0]) begin
        workNx  = PRODW'(trial - aux[OPW:0]);
        shNx[0] = 1'b1;
      end else begin
        workNx = PRODW'(trial);
      end
    end else begin
      if (sh[0]) workNx = work + aux;
      auxNx = aux << 1;
      shNx  = sh >> 1;
    end
  end

  assign prod    = negQ ? -workNx : workNx;
  assign prodExt = {{(ACCW + 1 - PRODW){prod[PRODW-1]}}, prod};
  assign macSum  = {1'b0, sumQ} + prodExt;
  assign qSigned = negQ ? -shNx : shNx;
  assign rSigned = negQ ? -workNx[OPW-1:0] : workNx[OPW-1:0];
  assign divRes  = (aux == '0) ? '0 : {{(ACCW - PRODW){1'b0}}, rSigned, qSigned};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA  <= '0;
      opB  <= '0;
      work <= '0;
      aux  <= '0;
      sh   <= '0;
      negQ <= 1'b0;
      sumQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (strb.start) begin
        work <= '0;
        opB  <= '0;
        if (strb.op == OP_DIV) begin
          aux  <= PRODW'(bFull);
          sh   <= absA;
          negQ <= opA[OPW-1];
          opA  <= '0;
        end else begin
          aux  <= PRODW'(absA);
          sh   <= absB;
          negQ <= opA[OPW-1] ^ bFull[OPW-1];
        end
      end else begin
        if (strb.wrALo) opA[7:0]     <= wrData;
        if (strb.wrAHi) opA[OPW-1:8] <= wrData;
        if (strb.wrBLo) opB[7:0]     <= wrData;
        if (strb.step) begin
          work <= workNx;
          aux  <= auxNx;
          sh   <= shNx;
        end
      end
      if (strb.finish) begin
        unique case (strb.op)
          OP_MUL:  sumQ <= prodExt[ACCW-1:0];
          OP_DIV:  sumQ <= divRes;
          default: {ovfQ, sumQ} <= macSum;
        endcase
      end else if (strb.clrSum) begin
        sumQ <= '0;
      end
    end
  end

endmodule

// File: rtl/arith_mdu.sv
module arith_mdu
  import mdu_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrIdx,
  input  logic [7:0] wrData,
  input  logic [2:0] rdIdx,
  output logic [7:0] rdData
);
  localparam int RES_BYTES = ACCW / 8;

  mduStrobes_t     strb;
  logic            busy;
  logic [ACCW-1:0] sumQ;
  logic            ovfQ;
  opKind_e         activeOp;

  assign activeOp = strb.op;

  mdu_ctrl #(.OPW(OPW)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .strb(strb), .busy(busy)
  );

  mdu_datapath #(.OPW(OPW), .ACCW(ACCW)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb),
    .sumQ(sumQ), .ovfQ(ovfQ)
  );

  always_comb begin
    rdData = '0;
    if (rdIdx == IDX_STATUS) rdData = {ovfQ, 6'd0, busy};
    for (int i = 0; i < RES_BYTES; i++) begin
      if (rdIdx == REG_IDXW'(i)) rdData = sumQ[i*8 +: 8];
    end
  end

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [2:0]      wrIdx,
  input logic [7:0]      wrData,
  input logic            busy,
  input logic [ACCW-1:0] sumQ,
  input logic            ovfQ,
  input opKind_e         activeOp
);
  localparam int PRODW = 2 * OPW;
  localparam int LENW  = $clog2(OPW) + 2;
  localparam logic [LENW-1:0] RUN_LEN = LENW'(OPW);

  logic [LENW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) runLen <= '0;
    else                runLen <= runLen + 1'b1;
  end

  // R9: an accepted trigger raises busy on the next cycle
  p_trigger_starts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_B_HI && !busy) |=> busy);

  // R9, R10: the busy window lasts exactly OPW cycles even with writes during it
  p_busy_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == RUN_LEN));

  p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < RUN_LEN));

  // R8: clear write while idle empties the total
  p_clear_total_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_CTRL && wrData[1] && !busy) |=> (sumQ == '0));

  // R8, R10: while idle and not cleared, the total holds
  p_total_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(wrEn && wrIdx == IDX_CTRL && wrData[1])) |=> $stable(sumQ));

  // R7: overflow only moves at an operation's completion
  p_ovf_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(ovfQ));

  // R4: a finished division leaves the top byte clear
  p_div_top_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(activeOp) == OP_DIV) |-> (sumQ[ACCW-1:PRODW] == '0));

endmodule

bind arith_mdu mdu_checker #(.OPW(OPW), .ACCW(ACCW)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
  .busy(busy), .sumQ(sumQ), .ovfQ(ovfQ), .activeOp(activeOp)
);

// File: tb/arith_mdu_tb_top.sv
module arith_mdu_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int MAX_CYC    = 190000;
  localparam logic [63:0] MASK40 = (64'd1 << 40) - 64'd1;

  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] wrIdx = '0, rdIdx = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int nChk = 0, nBad = 0, cyc = 0;

  arith_mdu dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == MAX_CYC) begin
      nBad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] s);
    rdIdx = 3'd5; #1; s = rdData;
  endtask

  task automatic readSum(output logic [63:0] v);
    v = '0;
    for (int i = 0; i < 5; i++) begin
      rdIdx = 3'(i); #1; v[i*8 +: 8] = rdData;
    end
  endtask

  task automatic waitIdle(output int n);
    logic [7:0] s;
    n = 0;
    readStatus(s);
    while (s[0] && n < 100) begin
      n++;
      @(negedge clk);
      readStatus(s);
    end
  endtask

  task automatic loadA(input logic [15:0] a);
    wrReg(3'd1, a[7:0]); wrReg(3'd2, a[15:8]);
  endtask

  task automatic runOp(input logic [15:0] a, input logic [15:0] b);
    int n;
    loadA(a);
    wrReg(3'd3, b[7:0]); wrReg(3'd4, b[15:8]);
    waitIdle(n);
  endtask

  function automatic logic [63:0] mulExp(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return 64'(p) & MASK40;
  endfunction

  function automatic logic [63:0] divExp(input int a, input int b);
    int mag, q, r;
    if (b == 0) return 64'd0;
    mag = (a < 0) ? -a : a;
    q = mag / b; r = mag % b;
    if (a < 0) begin q = -q; r = -r; end
    return (64'(r & 32'hFFFF) << 16) | 64'(q & 32'hFFFF);
  endfunction

  int vals[12] = '{0, 1, -1, 2, -3, 127, -128, 255, -256, 12345, -32768, 32767};
  int dvs[12]  = '{0, 1, 2, 3, 7, 255, 256, 1000, 32767, 32768, 65535, 40000};

  initial begin
    logic [63:0] v;
    logic [7:0]  s;
    longint      model;
    longint      t;
    logic        mOvf;
    int          n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2: reset values on every readable index
    readSum(v);    check("R1 result after reset", v, 64'd0);
    readStatus(s); check("R1 status after reset", 64'(s), 64'd0);
    rdIdx = 3'd6; #1; check("R2 unused read index", 64'(rdData), 64'd0);

    // R3: signed multiply sweep
    wrReg(3'd0, 8'h00);
    foreach (vals[i]) foreach (vals[j]) begin
      runOp(16'(vals[i]), 16'(vals[j]));
      readSum(v);
      check($sformatf("R3 mul %0d*%0d", vals[i], vals[j]), v, mulExp(vals[i], vals[j]));
    end

    // R4, R5: divide sweep, divisor unsigned
    wrReg(3'd0, 8'h01);
    foreach (vals[i]) foreach (dvs[j]) begin
      runOp(16'(vals[i]), 16'(dvs[j]));
      readSum(v);
      if (dvs[j] == 0) check($sformatf("R5 div %0d/0", vals[i]), v, 64'd0);
      else check($sformatf("R4 div %0d/%0d", vals[i], dvs[j]), v, divExp(vals[i], dvs[j]));
    end

    // R9: busy length
    wrReg(3'd0, 8'h00);
    loadA(16'd3); wrReg(3'd3, 8'd5); wrReg(3'd4, 8'd0);
    waitIdle(n);
    check("R9 busy cycles", 64'(n), 64'd16);
    readSum(v); check("R9 result after busy", v, 64'd15);

    // R10: writes while busy dropped
    loadA(16'd3); wrReg(3'd3, 8'd5); wrReg(3'd4, 8'd0);
    wrReg(3'd0, 8'h02);
    wrReg(3'd4, 8'h7F);
    waitIdle(n);
    readSum(v); check("R10 clear and retrigger ignored", v, 64'd15);
    wrReg(3'd3, 8'd4); wrReg(3'd4, 8'd0);
    waitIdle(n);
    readSum(v); check("R10 mode write ignored", v, 64'd12);

    // R11: operand clearing
    wrReg(3'd4, 8'h01);
    waitIdle(n);
    readSum(v); check("R11 B cleared, A kept", v, 64'd768);
    wrReg(3'd0, 8'h01);
    runOp(16'd100, 16'd7);
    readSum(v); check("R11 div before A clear", v, (64'd2 << 16) | 64'd14);
    wrReg(3'd0, 8'h00);
    wrReg(3'd3, 8'd2); wrReg(3'd4, 8'd0);
    waitIdle(n);
    readSum(v); check("R11 A cleared after div", v, 64'd0);

    // R7, R8: underflow, clear and flag retention
    wrReg(3'd0, 8'h02);
    readSum(v); check("R8 clear on mode 2", v, 64'd0);
    runOp(-16'sd3, 16'd5);
    readSum(v); check("R6 negative accumulate wraps", v, (64'd1 << 40) - 64'd15);
    readStatus(s); check("R7 underflow flag", 64'(s[7]), 64'd1);
    wrReg(3'd0, 8'h00);
    readSum(v); check("R8 no clear when bit1 low", v, (64'd1 << 40) - 64'd15);
    runOp(16'd7, -16'sd9);
    readStatus(s); check("R7 multiply keeps flag", 64'(s[7]), 64'd1);
    wrReg(3'd0, 8'h03);
    readSum(v);    check("R8 clear on mode 3", v, 64'd0);
    readStatus(s); check("R7 clear keeps flag", 64'(s[7]), 64'd1);

    // R3, R6, R7: accumulate sequence in mode 3 against model
    model = 0;
    for (int k = 0; k < 10; k++) begin
      runOp(16'(vals[k]), 16'(vals[11-k]));
      t = model + longint'(vals[k]) * longint'(vals[11-k]);
      mOvf = (t < 0) || (t >= (64'sd1 <<< 40));
      model = t & longint'(MASK40);
      readSum(v);    check($sformatf("R6 mac step %0d", k), v, 64'(model));
      readStatus(s); check($sformatf("R7 mac flag %0d", k), 64'(s[7]), 64'(mOvf));
    end

    // R7: overflow at exactly 2^40
    wrReg(3'd0, 8'h02);
    loadA(16'h8000);
    for (int k = 0; k < 1024; k++) begin
      wrReg(3'd3, 8'h00); wrReg(3'd4, 8'h80);
      waitIdle(n);
      if (k == 1022) begin
        readSum(v);    check("R6 total just below 2^40", v, (64'd1 << 40) - (64'd1 << 30));
        readStatus(s); check("R7 no flag below 2^40", 64'(s[7]), 64'd0);
      end
    end
    readSum(v);    check("R6 total wraps to zero", v, 64'd0);
    readStatus(s); check("R7 flag at 2^40", 64'(s[7]), 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule